// File: doc/BRIEF.md
# Asynchronous Trigger/Busy Handshake Controller

This block connects the local trigger decision logic to one device under test whose clock has no known relationship to the local clock. When a trigger request arrives and the link is free, the block raises its trigger line and holds a veto so that no further trigger is accepted. The device answers by raising busy. Once busy has been seen, the trigger line is dropped. The device then releases busy, and the block frees the link for the next trigger.

A readout option adds a serial transfer of the trigger number after the trigger line drops. The device toggles its own clock line, and each rising edge of that line, once synchronized, moves the serial output on to the next bit of the number, least significant bit first. All lines from the device pass through a two-flop synchronizer, and edges are detected only on the synchronized copies.

Top module: `trig_busy_link`

## Requirements
- R1: While reset is asserted and right after it, trigOut, serialOut and vetoOut are all low.
- R2: A trigReq sampled high at a clock edge while vetoOut is low raises both trigOut and vetoOut from that edge on.
- R3: trigReq is ignored while vetoOut is high, including the edge where the handshake completes; the number latched at acceptance is kept.
- R4: trigOut stays high until busy is seen through the synchronizer; it falls on the third rising clock edge after the edge that first samples busyIn high.
- R5: With readout off, vetoOut falls on the third rising clock edge after the edge that first samples busyIn low, once trigOut has already fallen.
- R6: The trigger number is captured from trigNum at the edge that accepts the trigger; later changes on trigNum do not alter the bits sent.
- R7: With readout on, serialOut shows bit 0 of the captured number as soon as trigOut falls; the third clock edge after the edge that samples a rising dutClkIn advances it by one bit, least significant bit first.
- R8: serialOut is 0 whenever no readout is in progress: while idle, while trigOut is high, when readout is off, and after all NUM_W bits have been sent.
- R9: With readout on, vetoOut stays high until both busy is seen low and all NUM_W bits have been sent; it falls one edge after the later of the two.
- R10: Rising edges on dutClkIn while trigOut is high, or after all bits are sent, move no bit.
- R11: numReadEn is sampled at the edge that accepts a trigger; changes during the handshake have no effect on that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigReq | input | 1 | Trigger request from the trigger logic |
| busyIn | input | 1 | Busy line from the device, asynchronous |
| dutClkIn | input | 1 | Readout clock from the device, asynchronous |
| trigNum | input | NUM_W (15) | Current trigger number |
| numReadEn | input | 1 | Enables serial number readout for the accepted trigger |
| trigOut | output | 1 | Trigger line to the device |
| serialOut | output | 1 | Serial trigger-number data |
| vetoOut | output | 1 | High while a handshake is in progress |

## Verification
Two pairs of events can fall in one cycle: the handshake completing while a new trigger request is already held high, and the last readout edge arriving in the same cycle that busy is seen low. The bench holds trigReq high across completion and expects vetoOut low for exactly one cycle before a new acceptance, and it drives busyIn low at the same instant as the final dutClkIn rise, expecting vetoOut to fall one edge after the last bit shifts. A behavioural model with queue-based synchronizer delays is compared against all three outputs on every clock.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIG  = 2'd1,
    ST_DRAIN = 2'd2
  } linkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture number and readout mode
    logic shift;  // advance one bit
    logic show;   // readout window open
  } dpCmd_t;

endpackage

// File: rtl/trig_busy_sync.sv
module trig_busy_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= '0;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/trig_busy_ctrl.sv
module trig_busy_ctrl
  import trig_busy_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   trigReq,
  input  logic   busySync,
  input  logic   dutSync,
  input  logic   readDone,
  output dpCmd_t cmd,
  output logic   trigOut,
  output logic   vetoOut
);

  linkState_e state, stateNext;
  logic       dutPrev;
  logic       dutRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dutPrev <= 1'b0;
    else       dutPrev <= dutSync;
  end

  assign dutRise = dutSync & ~dutPrev;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (trigReq)              stateNext = ST_TRIG;
      ST_TRIG:  if (busySync)             stateNext = ST_DRAIN;
      ST_DRAIN: if (!busySync && readDone) stateNext = ST_IDLE;
      default:                            stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cmd.load  = (state == ST_IDLE) && trigReq;
    cmd.shift = (state == ST_DRAIN) && dutRise;
    cmd.show  = (state == ST_DRAIN);
  end

  assign trigOut = (state == ST_TRIG);
  assign vetoOut = (state != ST_IDLE);

endmodule

// File: rtl/trig_busy_dp.sv
module trig_busy_dp
  import trig_busy_pkg::*;
#(
  parameter int NUM_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [NUM_W-1:0] trigNum,
  input  logic             numReadEn,
  output logic             readDone,
  output logic             serialOut
);

  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_W);

  logic [NUM_W-1:0] numReg;
  logic [CNT_W-1:0] bitCnt;
  logic             readMode;
  logic             allSent;

  assign allSent = (bitCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numReg   <= '0;
      bitCnt   <= '0;
      readMode <= 1'b0;
    end else if (cmd.load) begin
      numReg   <= trigNum;
      bitCnt   <= '0;
      readMode <= numReadEn;
    end else if (cmd.shift && !allSent) begin
      numReg   <= numReg >> 1;
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign readDone  = !readMode || allSent;
  assign serialOut = cmd.show & readMode & ~allSent & numReg[0];

endmodule

// File: rtl/trig_busy_link.sv
module trig_busy_link
  import trig_busy_pkg::*;
#(
  parameter int NUM_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigReq,
  input  logic             busyIn,
  input  logic             dutClkIn,
  input  logic [NUM_W-1:0] trigNum,
  input  logic             numReadEn,
  output logic             trigOut,
  output logic             serialOut,
  output logic             vetoOut
);

  logic   busySync;
  logic   dutSync;
  logic   readDone;
  dpCmd_t cmd;

  trig_busy_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({dutClkIn, busyIn}),
    .syncOut ({dutSync, busySync})
  );

  trig_busy_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigReq  (trigReq),
    .busySync (busySync),
    .dutSync  (dutSync),
    .readDone (readDone),
    .cmd      (cmd),
    .trigOut  (trigOut),
    .vetoOut  (vetoOut)
  );

  trig_busy_dp #(.NUM_W(NUM_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .trigNum   (trigNum),
    .numReadEn (numReadEn),
    .readDone  (readDone),
    .serialOut (serialOut)
  );

endmodule

// File: rtl/trig_busy_link_chk.sv
module trig_busy_link_chk (
  input logic clk,
  input logic rstN,
  input logic trigOut,
  input logic vetoOut,
  input logic serialOut,
  input logic busySync
);

  // R2: trigger never leaves without the veto held
  p_trig_vetoed_r2: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> vetoOut);

  // R2: a new handshake always starts with the trigger line
  p_veto_starts_trig_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vetoOut) |-> trigOut);

  // R4: trigger drops only after busy was seen through the synchronizer
  p_trig_drop_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigOut) |-> $past(busySync));

  // R5: rearm only after busy was seen low and trigger was already down
  p_rearm_busy_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vetoOut) |-> (!$past(busySync) && !$past(trigOut)));

  // R8: no serial data outside a handshake or during the trigger phase
  p_serial_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!vetoOut || trigOut) |-> !serialOut);

endmodule

bind trig_busy_link trig_busy_link_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .trigOut   (trigOut),
  .vetoOut   (vetoOut),
  .serialOut (serialOut),
  .busySync  (busySync)
);

// File: tb/test_trig_busy_link.sv
`timescale 1ns/1ps
module test_trig_busy_link;

  localparam int NW = 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trigReq = 1'b0;
  logic          busyIn = 1'b0;
  logic          dutClkIn = 1'b0;
  logic [NW-1:0] trigNum = '0;
  logic          numReadEn = 1'b0;
  logic          trigOut, serialOut, vetoOut;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  trig_busy_link i_trig_busy_link (
    .clk(clk), .rstN(rstN), .trigReq(trigReq), .busyIn(busyIn),
    .dutClkIn(dutClkIn), .trigNum(trigNum), .numReadEn(numReadEn),
    .trigOut(trigOut), .serialOut(serialOut), .vetoOut(vetoOut)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference model
  int mSt = 0;
  int mNum = 0;
  int mMode = 0;
  int mIdx = 0;
  int mDutLast = 0;
  int busyQ[$];
  int dutQ[$];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mNum = 0; mMode = 0; mIdx = 0; mDutLast = 0;
      busyQ = '{0, 0};
      dutQ  = '{0, 0};
    end else begin
      int bSeen, dNow, rise, done;
      bSeen = busyQ.pop_front();
      busyQ.push_back(int'(busyIn));
      dNow = dutQ.pop_front();
      dutQ.push_back(int'(dutClkIn));
      rise = (dNow == 1 && mDutLast == 0) ? 1 : 0;
      mDutLast = dNow;
      case (mSt)
        0: if (trigReq) begin
             mSt = 1; mNum = int'(trigNum); mMode = int'(numReadEn); mIdx = 0;
           end
        1: if (bSeen == 1) mSt = 2;
        default: begin
          done = (mMode == 0 || mIdx == NW) ? 1 : 0;
          if (rise == 1 && mIdx < NW) mIdx++;
          if (bSeen == 0 && done == 1) mSt = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic eSer;
      eSer = (mSt == 2 && mMode == 1 && mIdx < NW) ? logic'((mNum >> mIdx) & 1) : 1'b0;
      chk("R4 model trigOut", trigOut, logic'(mSt == 1));
      chk("R9 model vetoOut", vetoOut, logic'(mSt != 0));
      chk("R7 model serialOut", serialOut, eSer);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  // readout handshake; busy is dropped together with the rise for bit dropAt
  task automatic readTrig(input logic [NW-1:0] n, input int dropAt);
    trigNum = n; numReadEn = 1'b1; trigReq = 1'b1;
    step(1);
    chk("R2 trig up", trigOut, 1'b1);
    trigReq = 1'b0; numReadEn = 1'b0; trigNum = ~n;  // R6, R11
    dutClkIn = 1'b1; step(3); dutClkIn = 1'b0; step(3);  // R10 ignored edge
    chk("R8 serial during trig", serialOut, 1'b0);
    busyIn = 1'b1; step(3);
    chk("R4 trig down", trigOut, 1'b0);
    chk("R10 bit0 after early edge", serialOut, n[0]);
    for (int i = 1; i <= NW; i++) begin
      dutClkIn = 1'b1;
      if (i == dropAt) busyIn = 1'b0;
      step(3);
      if (i < NW) chk("R7 bit", serialOut, n[i]);
      else        chk("R8 after last bit", serialOut, 1'b0);
      if (i < NW) chk("R9 veto held", vetoOut, 1'b1);
      dutClkIn = 1'b0; step(2);
      if (i == NW) chk("R9 veto released", vetoOut, 1'b0);
    end
    dutClkIn = 1'b1; step(3); dutClkIn = 1'b0; step(2);
    chk("R10 edge after done", serialOut, 1'b0);
  endtask

  initial begin
    step(2);
    chk("R1 trig reset", trigOut, 1'b0);
    chk("R1 serial reset", serialOut, 1'b0);
    chk("R1 veto reset", vetoOut, 1'b0);
    rstN = 1'b1;
    step(2);
    chk("R1 veto after reset", vetoOut, 1'b0);

    // no readout; request held through completion
    trigNum = 15'h1234; numReadEn = 1'b0; trigReq = 1'b1;
    step(1);
    chk("R2 trig", trigOut, 1'b1);
    chk("R2 veto", vetoOut, 1'b1);
    trigNum = 15'h0777;
    step(3);
    chk("R4 trig waits busy", trigOut, 1'b1);
    busyIn = 1'b1; step(2);
    chk("R4 trig before sync", trigOut, 1'b1);
    step(1);
    chk("R4 trig fell", trigOut, 1'b0);
    chk("R8 serial readout off", serialOut, 1'b0);
    dutClkIn = 1'b1;
    busyIn = 1'b0; step(2);
    chk("R5 veto before sync", vetoOut, 1'b1);
    chk("R8 serial readout off toggled", serialOut, 1'b0);
    step(1);
    chk("R3 veto low one cycle", vetoOut, 1'b0);
    step(1);
    chk("R3 reaccept after completion", trigOut, 1'b1);
    trigReq = 1'b0; dutClkIn = 1'b0;
    busyIn = 1'b1; step(4); busyIn = 1'b0; step(4);
    chk("R5 veto low again", vetoOut, 1'b0);

    // readout, busy drops mid-stream
    readTrig(15'h5A3C, 6);
    step(3);
    // readout, busy drop coincides with the last rising edge
    readTrig(15'h7FFF, NW);
    step(3);
    readTrig(15'h0001, 2);
    step(5);
    chk("R8 idle serial", serialOut, 1'b0);

    summary();
    $finish;
  end

endmodule